// File: doc/BRIEF.md
# SCSI Initiator Message-In Decoder

This block handles the message-in phase on the initiator side of a parallel SCSI bus. The target raises REQ with a byte on the data lines. The block reads that byte straight from the bus and decides what it means. It acknowledges the byte only after that decision is made. Because of this, a reply such as a reject or a device reset can be queued while the target is still holding the offending byte. Each finished decision is reported as a one-cycle event code. Where a reply is needed, the block also raises a one-byte message-out request together with an ATN request.

The block is armed by a start pulse once the surrounding sequencer has seen the bus enter message-in. It then walks through the rest of the message by itself. This covers the following:
- a lone byte;
- an IDENTIFY from a reselecting target, followed by an optional queue-tag snoop when no untagged command matches;
- an extended message, whose body is kept in a small capped buffer, and whose final byte waits for a host verdict.

Slot lookup is not part of this block. A single input reports whether an untagged slot matched the reselecting target. DMA and pointer bookkeeping are also outside the block. Only a data-phase-seen flag is kept, because it gates the save-pointers event.

Top module: `msgin_decoder`

## Requirements
- R1: After synchronous reset, ack_o, evt_valid_o, msgout_req_o, atn_o and done_o are all low, and the block is idle.
- R2: A byte is accepted only while armed. The block is armed by start_i or by seeing req_i low, with req_i high and perr_i low. A REQ that carries a parity error is ignored until perr_i clears. Every ack_o is a single-cycle pulse, and the first byte is kept on first_byte_o.
- R3: The first byte is classified, and event codes appear on evt_code_o with evt_valid_o. The one-byte cases are:
  - 0x04 gives code 1 (disconnect).
  - 0x00 gives code 4 (command complete).
  - 0x07 gives code 6 (reject received).
  - 0x08 (no-op) is acknowledged with no event.
- R4: A data-phase flag is set by dphase_set_i. Byte 0x03 clears the flag and reports code 3 (restore). Byte 0x02 reports code 2 (save) only when the flag is set; otherwise it is acknowledged silently.
- R5: An unrecognised first byte (bit 7 clear, not in R3 or R4) produces the following, and the byte is then acknowledged:
  - code 9 (send reject);
  - msgout_req_o with byte 0x07;
  - atn_o.
- R6: A byte with bit 7 set is an IDENTIFY. If any of bits 6:3 are set (mask 0x78), it is handled as in R5. Otherwise lun_o takes bits 2:0. If untagged_hit_i is high, code 10 is reported and the byte is acknowledged.
- R7: For an IDENTIFY with untagged_hit_i low, the byte is acknowledged and the next REQ is examined before it is acknowledged. If phase_i is 3'b111 (message-in) and the byte is 0x20, the byte is acknowledged and the tag byte follows. Any other case reports code 7 (no match) with a message-out request for byte 0x0C and atn_o; it acknowledges only if the phase is message-in.
- R8: The tag byte is compared against SLOTS. A tag below SLOTS reports code 11 and appears on tag_o. A tag at or above SLOTS reports code 7 with byte 0x0C and atn_o. The tag byte is acknowledged in both cases.
- R9: First byte 0x01 starts an extended message. The next byte is the length, kept on ext_len_o, and that many body bytes follow. Body bytes fill EXT_DEPTH slots in order on ext_bytes_o (slot 0 in the low byte), and any extra bytes overwrite the last slot. After the last body byte (or a zero length), code 5 is reported and that byte stays unacknowledged.
- R10: The final extended byte is acknowledged when host_reply_valid_i arrives. The reply codes on host_reply_i are:
  - 0 or 3: acknowledge only.
  - 1: reject, handled as in R5.
  - 2: atn_o pulse with no message-out request, so the host's own prepared message is sent.
- R11: If phase_i is not message-in while a tag byte or an extended length or body byte is expected, code 8 (phase mismatch) is reported. The byte is not acknowledged, and the block finishes.
- R12: done_o pulses when the handling of a message ends. While idle, REQ is never acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Arm the block for a new message-in sequence |
| req_i | input | 1 | Target REQ |
| perr_i | input | 1 | Parity error on the current REQ byte |
| phase_i | input | PHASE_W | Current bus phase (MSG, C/D, I/O) |
| data_i | input | 8 | Byte on the bus |
| untagged_hit_i | input | 1 | An untagged slot matches the reselecting target |
| dphase_set_i | input | 1 | A data phase has taken place |
| host_reply_valid_i | input | 1 | Host verdict on an extended message is present |
| host_reply_i | input | 2 | Host verdict code |
| ack_o | output | 1 | ACK pulse for the held byte |
| evt_valid_o | output | 1 | Event code valid |
| evt_code_o | output | 4 | Event code |
| msgout_req_o | output | 1 | Request to queue a one-byte message-out |
| msgout_byte_o | output | 8 | Message-out byte |
| atn_o | output | 1 | Request to raise ATN |
| done_o | output | 1 | Message handling finished |
| first_byte_o | output | 8 | First byte of the last message |
| lun_o | output | 3 | Logical unit from the last IDENTIFY |
| tag_o | output | 8 | Last snooped tag |
| ext_len_o | output | 8 | Extended-message length |
| ext_bytes_o | output | 8*EXT_DEPTH | Extended-message body slots |

## Verification
The states that are hardest to reach are deep inside multi-byte sequences. Examples are the tag-byte range boundary after an unmatched IDENTIFY, and the overwrite of the last extended slot. Both need a target model that answers each ACK with a fresh REQ, so the bench drives REQ/ACK as a full handshake and changes the phase or byte only between handshakes. The held final extended byte is checked by letting the bench leave REQ high with no ACK, then sending each host verdict. The snoop path is checked by presenting an unexpected phase in place of the tag so that the block must leave it unacknowledged.

// File: rtl/msgin_pkg.sv
package msgin_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    EV_NONE      = 4'd0,
    EV_DISC      = 4'd1,
    EV_SAVE      = 4'd2,
    EV_RESTORE   = 4'd3,
    EV_COMPLETE  = 4'd4,
    EV_EXTENDED  = 4'd5,
    EV_REJ_RCVD  = 4'd6,
    EV_NO_MATCH  = 4'd7,
    EV_PHASE_MIS = 4'd8,
    EV_SEND_REJ  = 4'd9,
    EV_IDENT_OK  = 4'd10,
    EV_TAG_OK    = 4'd11
  } evt_e;

  typedef enum logic [3:0] {
    C_UNKNOWN, C_IDENT, C_IDENT_BAD, C_DISC, C_SAVE,
    C_RESTORE, C_COMPLETE, C_EXT, C_REJ, C_NOOP
  } cls_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FIRST, S_SNOOP, S_TAG, S_XLEN, S_XDATA, S_HOST
  } st_e;

  localparam logic [7:0] M_COMPLETE   = 8'h00;
  localparam logic [7:0] M_EXT        = 8'h01;
  localparam logic [7:0] M_SAVE       = 8'h02;
  localparam logic [7:0] M_RESTORE    = 8'h03;
  localparam logic [7:0] M_DISC       = 8'h04;
  localparam logic [7:0] M_REJECT     = 8'h07;
  localparam logic [7:0] M_NOOP       = 8'h08;
  localparam logic [7:0] M_BDR        = 8'h0C;
  localparam logic [7:0] M_SIMPLE_TAG = 8'h20;
  localparam logic [7:0] IDENT_RSVD   = 8'h78;
endpackage

// File: rtl/msgin_classify.sv
module msgin_classify
  import msgin_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output cls_e              cls_o
);
  always_comb begin
    if (byte_i[BYTE_W-1]) begin
      cls_o = ((byte_i & IDENT_RSVD) != '0) ? C_IDENT_BAD : C_IDENT;
    end else begin
      unique case (byte_i)
        M_DISC:     cls_o = C_DISC;
        M_SAVE:     cls_o = C_SAVE;
        M_COMPLETE: cls_o = C_COMPLETE;
        M_RESTORE:  cls_o = C_RESTORE;
        M_EXT:      cls_o = C_EXT;
        M_REJECT:   cls_o = C_REJ;
        M_NOOP:     cls_o = C_NOOP;
        default:    cls_o = C_UNKNOWN;
      endcase
    end
  end
endmodule

// File: rtl/msgin_tag_check.sv
module msgin_tag_check #(
  parameter int TAG_W = 8,
  parameter int SLOTS = 16
) (
  input  logic [TAG_W-1:0] tag_i,
  output logic             in_range_o
);
  // tag + (2^TAG_W - SLOTS) carries out exactly when tag >= SLOTS
  localparam int unsigned NEG_I = (1 << TAG_W) - SLOTS;
  localparam logic [TAG_W:0] NEG = NEG_I[TAG_W:0];
  logic [TAG_W:0] sum;
  always_comb begin
    sum        = {1'b0, tag_i} + NEG;
    in_range_o = ~sum[TAG_W];
  end
endmodule

// File: rtl/msgin_ext_store.sv
module msgin_ext_store #(
  parameter int DEPTH = 3,
  parameter int W     = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic               we_i,
  input  logic [W-1:0]       d_i,
  output logic [DEPTH*W-1:0] bytes_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst || clr_i) idx <= '0;
    else if (we_i && idx != LAST) idx <= idx + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst) slot_q <= '0;
      else if (we_i && idx == IDX_W'(g)) slot_q <= d_i;
    end
    assign bytes_o[g*W +: W] = slot_q;
  end

  // R9: the write pointer saturates on the last slot
  p_idx_cap_r9: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST);
endmodule

// File: rtl/msgin_decoder.sv
module msgin_decoder
  import msgin_pkg::*;
#(
  parameter int SLOTS       = 16,
  parameter int EXT_DEPTH   = 3,
  parameter int PHASE_W     = 3,
  parameter logic [PHASE_W-1:0] PHASE_MSGIN = 3'b111
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic                      req_i,
  input  logic                      perr_i,
  input  logic [PHASE_W-1:0]        phase_i,
  input  logic [7:0]                data_i,
  input  logic                      untagged_hit_i,
  input  logic                      dphase_set_i,
  input  logic                      host_reply_valid_i,
  input  logic [1:0]                host_reply_i,
  output logic                      ack_o,
  output logic                      evt_valid_o,
  output logic [3:0]                evt_code_o,
  output logic                      msgout_req_o,
  output logic [7:0]                msgout_byte_o,
  output logic                      atn_o,
  output logic                      done_o,
  output logic [7:0]                first_byte_o,
  output logic [2:0]                lun_o,
  output logic [7:0]                tag_o,
  output logic [7:0]                ext_len_o,
  output logic [8*EXT_DEPTH-1:0]    ext_bytes_o
);
  localparam logic [8:0] SLOTS_V = 9'(SLOTS);

  st_e        st;
  logic       armed;
  logic       dflag;
  logic [7:0] rem;
  cls_e       cls;
  logic       tag_ok;
  logic       take;
  logic       phase_ok;
  logic       ext_we;
  logic       ext_clr;

  assign take     = armed & req_i & ~perr_i;
  assign phase_ok = (phase_i == PHASE_MSGIN);
  assign ext_we   = (st == S_XDATA) & take & phase_ok;
  assign ext_clr  = (st == S_XLEN)  & take & phase_ok;

  msgin_classify u_cls (.byte_i(data_i), .cls_o(cls));

  msgin_tag_check #(.TAG_W(8), .SLOTS(SLOTS)) u_tag (
    .tag_i(data_i), .in_range_o(tag_ok));

  msgin_ext_store #(.DEPTH(EXT_DEPTH), .W(8)) u_ext (
    .clk(clk), .rst(rst), .clr_i(ext_clr), .we_i(ext_we),
    .d_i(data_i), .bytes_o(ext_bytes_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      armed         <= 1'b0;
      dflag         <= 1'b0;
      rem           <= '0;
      ack_o         <= 1'b0;
      evt_valid_o   <= 1'b0;
      evt_code_o    <= EV_NONE;
      msgout_req_o  <= 1'b0;
      msgout_byte_o <= '0;
      atn_o         <= 1'b0;
      done_o        <= 1'b0;
      first_byte_o  <= '0;
      lun_o         <= '0;
      tag_o         <= '0;
      ext_len_o     <= '0;
    end else begin
      ack_o        <= 1'b0;
      evt_valid_o  <= 1'b0;
      msgout_req_o <= 1'b0;
      atn_o        <= 1'b0;
      done_o       <= 1'b0;
      if (!req_i)       armed <= 1'b1;
      if (dphase_set_i) dflag <= 1'b1;

      unique case (st)
        S_IDLE: if (start_i) begin
          st    <= S_FIRST;
          armed <= 1'b1;
        end

        S_FIRST: if (take) begin
          first_byte_o <= data_i;
          ack_o        <= 1'b1;
          armed        <= 1'b0;
          done_o       <= 1'b1;
          st           <= S_IDLE;
          unique case (cls)
            C_IDENT: begin
              lun_o <= data_i[2:0];
              if (untagged_hit_i) begin
                evt_valid_o <= 1'b1; evt_code_o <= EV_IDENT_OK;
              end else begin
                done_o <= 1'b0; st <= S_SNOOP;
              end
            end
            C_IDENT_BAD, C_UNKNOWN: begin
              evt_valid_o   <= 1'b1; evt_code_o <= EV_SEND_REJ;
              msgout_req_o  <= 1'b1; msgout_byte_o <= M_REJECT;
              atn_o         <= 1'b1;
            end
            C_DISC:     begin evt_valid_o <= 1'b1; evt_code_o <= EV_DISC; end
            C_COMPLETE: begin evt_valid_o <= 1'b1; evt_code_o <= EV_COMPLETE; end
            C_REJ:      begin evt_valid_o <= 1'b1; evt_code_o <= EV_REJ_RCVD; end
            C_RESTORE: begin
              dflag <= 1'b0;
              evt_valid_o <= 1'b1; evt_code_o <= EV_RESTORE;
            end
            C_SAVE: if (dflag) begin
              evt_valid_o <= 1'b1; evt_code_o <= EV_SAVE;
            end
            C_EXT: begin done_o <= 1'b0; st <= S_XLEN; end
            default: ;
          endcase
        end

        S_SNOOP: if (take) begin
          if (phase_ok && data_i == M_SIMPLE_TAG) begin
            ack_o <= 1'b1; armed <= 1'b0; st <= S_TAG;
          end else begin
            evt_valid_o  <= 1'b1; evt_code_o <= EV_NO_MATCH;
            msgout_req_o <= 1'b1; msgout_byte_o <= M_BDR;
            atn_o        <= 1'b1;
            done_o       <= 1'b1; st <= S_IDLE;
            if (phase_ok) begin ack_o <= 1'b1; armed <= 1'b0; end
          end
        end

        S_TAG: if (take) begin
          done_o <= 1'b1; st <= S_IDLE;
          evt_valid_o <= 1'b1;
          if (!phase_ok) begin
            evt_code_o <= EV_PHASE_MIS;
          end else begin
            ack_o <= 1'b1; armed <= 1'b0;
            tag_o <= data_i;
            if (tag_ok) begin
              evt_code_o <= EV_TAG_OK;
            end else begin
              evt_code_o   <= EV_NO_MATCH;
              msgout_req_o <= 1'b1; msgout_byte_o <= M_BDR;
              atn_o        <= 1'b1;
            end
          end
        end

        S_XLEN: if (take) begin
          if (!phase_ok) begin
            evt_valid_o <= 1'b1; evt_code_o <= EV_PHASE_MIS;
            done_o <= 1'b1; st <= S_IDLE;
          end else begin
            ext_len_o <= data_i;
            rem       <= data_i;
            if (data_i == '0) begin
              evt_valid_o <= 1'b1; evt_code_o <= EV_EXTENDED;
              st <= S_HOST;
            end else begin
              ack_o <= 1'b1; armed <= 1'b0; st <= S_XDATA;
            end
          end
        end

        S_XDATA: if (take) begin
          if (!phase_ok) begin
            evt_valid_o <= 1'b1; evt_code_o <= EV_PHASE_MIS;
            done_o <= 1'b1; st <= S_IDLE;
          end else if (rem == 8'd1) begin
            evt_valid_o <= 1'b1; evt_code_o <= EV_EXTENDED;
            st <= S_HOST;
          end else begin
            rem   <= rem - 8'd1;
            ack_o <= 1'b1; armed <= 1'b0;
          end
        end

        S_HOST: if (host_reply_valid_i) begin
          ack_o  <= 1'b1; armed <= 1'b0;
          done_o <= 1'b1; st <= S_IDLE;
          unique case (host_reply_i)
            2'd1: begin
              evt_valid_o  <= 1'b1; evt_code_o <= EV_SEND_REJ;
              msgout_req_o <= 1'b1; msgout_byte_o <= M_REJECT;
              atn_o        <= 1'b1;
            end
            2'd2: atn_o <= 1'b1;
            default: ;
          endcase
        end

        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: acknowledge is never stretched
  p_ack_single_r2: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);

  // R11: a phase mismatch leaves the byte with the target
  p_phase_mis_noack_r11: assert property (@(posedge clk) disable iff (rst)
    (evt_valid_o && evt_code_o == EV_PHASE_MIS) |-> !ack_o);

  // R6: a clean IDENTIFY has bit 7 set and no reserved bits
  p_ident_clean_r6: assert property (@(posedge clk) disable iff (rst)
    (evt_valid_o && evt_code_o == EV_IDENT_OK) |->
      (first_byte_o[7] && first_byte_o[6:3] == 4'd0));

  // R8: an accepted tag lies below the slot count
  p_tag_range_r8: assert property (@(posedge clk) disable iff (rst)
    (evt_valid_o && evt_code_o == EV_TAG_OK) |-> ({1'b0, tag_o} < SLOTS_V));

  // R4: save event only with the data-phase flag set
  p_save_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (evt_valid_o && evt_code_o == EV_SAVE) |-> $past(dflag));

  // R12: nothing is acknowledged from idle
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !start_i) |=> !ack_o || $past(st != S_IDLE));
endmodule

// File: tb/msgin_decoder_tb_top.sv
`timescale 1ns/1ps
module msgin_decoder_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, req_i = 0, perr_i = 0, untagged_hit_i = 0;
  logic dphase_set_i = 0, host_reply_valid_i = 0;
  logic [1:0] host_reply_i = 0;
  logic [2:0] phase_i = 3'b111;
  logic [7:0] data_i = 0;
  logic ack_o, evt_valid_o, msgout_req_o, atn_o, done_o;
  logic [3:0] evt_code_o;
  logic [7:0] msgout_byte_o, first_byte_o, tag_o, ext_len_o;
  logic [2:0] lun_o;
  logic [23:0] ext_bytes_o;

  always #2 clk = ~clk;

  msgin_decoder dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .req_i(req_i), .perr_i(perr_i),
    .phase_i(phase_i), .data_i(data_i), .untagged_hit_i(untagged_hit_i),
    .dphase_set_i(dphase_set_i), .host_reply_valid_i(host_reply_valid_i),
    .host_reply_i(host_reply_i), .ack_o(ack_o), .evt_valid_o(evt_valid_o),
    .evt_code_o(evt_code_o), .msgout_req_o(msgout_req_o),
    .msgout_byte_o(msgout_byte_o), .atn_o(atn_o), .done_o(done_o),
    .first_byte_o(first_byte_o), .lun_o(lun_o), .tag_o(tag_o),
    .ext_len_o(ext_len_o), .ext_bytes_o(ext_bytes_o));

  typedef struct {
    logic [3:0] code;
    logic       mo;
    logic [7:0] mb;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string r, input string what,
                     input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, expv);
    end
  endtask

  task automatic expect_ev(input logic [3:0] c, input logic mo,
                           input logic [7:0] mb, input string r);
    exp_t e;
    e.code = c; e.mo = mo; e.mb = mb; e.req = r;
    exp_q.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (evt_valid_o) begin
        if (exp_q.size() == 0) begin
          chk(0, "R3", "unexpected event", int'(evt_code_o), 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(evt_code_o == e.code, e.req, "event code", int'(evt_code_o), int'(e.code));
          chk(msgout_req_o == e.mo && (!e.mo || msgout_byte_o == e.mb), e.req,
              "message-out", int'({msgout_req_o, msgout_byte_o}), int'({e.mo, e.mb}));
          if (e.mo) chk(atn_o, e.req, "atn with message-out", int'(atn_o), 1);
        end
      end else if (msgout_req_o) begin
        chk(0, "R5", "message-out without event", int'(msgout_byte_o), 0);
      end
    end
  end

  task automatic begin_msg();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
  endtask

  task automatic present(input logic [2:0] ph, input logic [7:0] d, input int maxc,
                         output bit acked, output bit dn);
    @(negedge clk);
    phase_i = ph; data_i = d; req_i = 1;
    acked = 0; dn = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (ack_o) begin
        acked = 1; dn = done_o; req_i = 0;
        break;
      end
    end
  endtask

  task automatic drop();
    @(negedge clk) req_i = 0;
  endtask

  task automatic host(input logic [1:0] code, output bit acked, output bit atn);
    @(negedge clk) host_reply_valid_i = 1; host_reply_i = code;
    @(negedge clk) host_reply_valid_i = 0;
    acked = ack_o; atn = atn_o;
    req_i = 0;
  endtask

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL R12 watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    bit a, dn, at;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!ack_o && !evt_valid_o && !msgout_req_o && !atn_o && !done_o, "R1",
        "outputs after reset", int'({ack_o, evt_valid_o, msgout_req_o, atn_o, done_o}), 0);

    // R3 disconnect, with done
    begin_msg(); expect_ev(4'd1, 0, 0, "R3");
    present(3'b111, 8'h04, 4, a, dn);
    chk(a, "R3", "disconnect ack", a, 1);
    chk(dn, "R12", "done with final ack", dn, 1);
    chk(first_byte_o == 8'h04, "R2", "first byte kept", first_byte_o, 8'h04);

    begin_msg(); expect_ev(4'd4, 0, 0, "R3");
    present(3'b111, 8'h00, 4, a, dn);
    begin_msg(); expect_ev(4'd6, 0, 0, "R3");
    present(3'b111, 8'h07, 4, a, dn);
    begin_msg();
    present(3'b111, 8'h08, 4, a, dn);
    chk(a, "R3", "no-op acked silently", a, 1);

    // R2 parity error holds off acceptance
    begin_msg(); expect_ev(4'd1, 0, 0, "R2");
    @(negedge clk) phase_i = 3'b111; data_i = 8'h04; req_i = 1; perr_i = 1;
    a = 0;
    repeat (3) begin @(negedge clk); if (ack_o) a = 1; end
    chk(!a, "R2", "no ack under parity error", a, 0);
    perr_i = 0;
    @(negedge clk);
    chk(ack_o, "R2", "ack once parity clears", ack_o, 1);
    req_i = 0;
    @(negedge clk);
    chk(!ack_o, "R2", "ack single pulse", ack_o, 0);

    // R4 data-phase flag
    begin_msg(); present(3'b111, 8'h02, 4, a, dn);
    chk(a, "R4", "save without flag acked", a, 1);
    @(negedge clk) dphase_set_i = 1;
    @(negedge clk) dphase_set_i = 0;
    begin_msg(); expect_ev(4'd2, 0, 0, "R4");
    present(3'b111, 8'h02, 4, a, dn);
    begin_msg(); expect_ev(4'd3, 0, 0, "R4");
    present(3'b111, 8'h03, 4, a, dn);
    begin_msg(); present(3'b111, 8'h02, 4, a, dn);

    // R5 unknown byte
    begin_msg(); expect_ev(4'd9, 1, 8'h07, "R5");
    present(3'b111, 8'h55, 4, a, dn);
    chk(a, "R5", "unknown byte acked", a, 1);

    // R6 identify
    untagged_hit_i = 1;
    begin_msg(); expect_ev(4'd10, 0, 0, "R6");
    present(3'b111, 8'h85, 4, a, dn);
    chk(lun_o == 3'd5, "R6", "lun", lun_o, 5);
    begin_msg(); expect_ev(4'd9, 1, 8'h07, "R6");
    present(3'b111, 8'hC8, 4, a, dn);
    untagged_hit_i = 0;

    // R7 / R8 tag snoop
    begin_msg(); expect_ev(4'd11, 0, 0, "R8");
    present(3'b111, 8'h83, 4, a, dn);
    chk(a && !dn, "R7", "identify acked, not done", int'({a, dn}), 2);
    present(3'b111, 8'h20, 4, a, dn);
    chk(a, "R7", "queue tag message acked", a, 1);
    present(3'b111, 8'h0F, 4, a, dn);
    chk(a && tag_o == 8'h0F, "R8", "tag 15 accepted", tag_o, 8'h0F);

    begin_msg(); expect_ev(4'd7, 1, 8'h0C, "R8");
    present(3'b111, 8'h81, 4, a, dn);
    present(3'b111, 8'h20, 4, a, dn);
    present(3'b111, 8'h10, 4, a, dn);
    chk(a, "R8", "out-of-range tag acked", a, 1);

    begin_msg(); expect_ev(4'd7, 1, 8'h0C, "R7");
    present(3'b111, 8'h82, 4, a, dn);
    present(3'b111, 8'h03, 4, a, dn);
    chk(a, "R7", "non-tag message-in byte acked", a, 1);

    begin_msg(); expect_ev(4'd7, 1, 8'h0C, "R7");
    present(3'b111, 8'h82, 4, a, dn);
    present(3'b011, 8'h00, 4, a, dn);
    chk(!a, "R7", "other phase not acked", a, 0);
    drop();

    // R11 phase change while tag expected
    begin_msg(); expect_ev(4'd8, 0, 0, "R11");
    present(3'b111, 8'h80, 4, a, dn);
    present(3'b111, 8'h20, 4, a, dn);
    present(3'b000, 8'h44, 4, a, dn);
    chk(!a, "R11", "mismatch byte not acked", a, 0);
    drop();

    // R9 / R10 extended with overflow, host asks for ATN
    begin_msg(); expect_ev(4'd5, 0, 0, "R9");
    present(3'b111, 8'h01, 4, a, dn);
    present(3'b111, 8'h05, 4, a, dn);
    chk(ext_len_o == 8'h05, "R9", "ext length", ext_len_o, 5);
    present(3'b111, 8'h11, 4, a, dn);
    present(3'b111, 8'h22, 4, a, dn);
    present(3'b111, 8'h33, 4, a, dn);
    present(3'b111, 8'h44, 4, a, dn);
    present(3'b111, 8'h55, 4, a, dn);
    chk(!a, "R9", "last ext byte held", a, 0);
    chk(ext_bytes_o == 24'h552211, "R9", "ext slots", ext_bytes_o, 24'h552211);
    host(2'd2, a, at);
    chk(a && at && !msgout_req_o, "R10", "host send reply",
        int'({a, at, msgout_req_o}), 6);

    begin_msg(); expect_ev(4'd5, 0, 0, "R9"); expect_ev(4'd9, 1, 8'h07, "R10");
    present(3'b111, 8'h01, 4, a, dn);
    present(3'b111, 8'h01, 4, a, dn);
    present(3'b111, 8'h66, 4, a, dn);
    host(2'd1, a, at);
    chk(a, "R10", "host reject acked", a, 1);

    begin_msg(); expect_ev(4'd5, 0, 0, "R9");
    present(3'b111, 8'h01, 4, a, dn);
    present(3'b111, 8'h00, 4, a, dn);
    chk(!a, "R9", "zero length held", a, 0);
    host(2'd0, a, at);
    chk(a && !at, "R10", "host plain ack", int'({a, at}), 2);

    begin_msg(); expect_ev(4'd8, 0, 0, "R11");
    present(3'b111, 8'h01, 4, a, dn);
    present(3'b111, 8'h03, 4, a, dn);
    present(3'b111, 8'h77, 4, a, dn);
    present(3'b010, 8'h00, 4, a, dn);
    chk(!a, "R11", "ext mismatch not acked", a, 0);
    drop();

    // R12 idle ignores REQ
    present(3'b111, 8'h04, 4, a, dn);
    chk(!a, "R12", "idle REQ not acked", a, 0);
    drop();

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "expected events left", exp_q.size(), 0);
    summary();
  end
endmodule